// File: doc/BRIEF.md
# Packed Double-Precision Maximum Unit

This block takes two 128-bit operands, each carrying two IEEE-754 binary64 values, and produces the maximum of each lane pair in a 128-bit result. The operands are not interchangeable. The first operand (`op_keep`) wins only when it is strictly greater than the second. In every other case the second operand (`op_alt`) is returned bit for bit. Those other cases include equal values, a pair of zeros of any sign, and any lane that holds a NaN.

The result, an invalid flag and a denormal flag are captured on the clock edge that sees `in_valid` high. `out_valid` then pulses for one cycle. Two mask inputs are sampled with the operands. The unit raises `exc_unmasked` when a raised flag is not masked. The unit never rounds and never alters a NaN payload, so a signalling NaN keeps its quiet bit clear.

Top module: `pfmax_unit`

## Requirements
- R1: Lane 0 uses operand bits 63..0 and lane 1 uses bits 127..64. Each lane's result depends only on that lane's operand bits.
- R2: For ordinary non-zero, non-NaN values, the ordering is sign-magnitude. A positive value beats a negative one. Between two positives the larger magnitude wins, and between two negatives the smaller magnitude wins. The first operand is returned only when it is strictly greater than the second; otherwise the second operand is returned.
- R3: When the two values in a lane are equal, the second operand is returned.
- R4: When both values in a lane are zero, the second operand is returned whatever the two signs are. Zero means exponent and fraction both zero, so +0 is 0x0000000000000000 and -0 is 0x8000000000000000.
- R5: If either value in a lane is a NaN, the second operand is returned unchanged.
  - A NaN has exponent 0x7FF and a non-zero fraction. It is signalling when fraction bit 51 is 0.
  - A signalling NaN that is returned keeps bit 51 at 0.
- R6: `flag_inv` is 1 when any lane input, in either operand, is a NaN of either kind.
- R7: `flag_den` is 1 when any lane input is subnormal, meaning exponent 0 with a non-zero fraction.
- R8: `exc_unmasked` equals (`flag_inv` AND NOT `mask_inv`) OR (`flag_den` AND NOT `mask_den`). The masks used are the ones sampled with the same strobe.
- R9: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. Back-to-back strobes give back-to-back results. Without a strobe, `result` and the flags hold their values.
- R10: A synchronous active-high reset clears `out_valid`, `result`, `flag_inv`, `flag_den` and `exc_unmasked` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe that captures operands and masks |
| op_keep | input | 128 | First operand, two binary64 lanes |
| op_alt | input | 128 | Second operand, favoured on ties, zeros and NaNs |
| mask_inv | input | 1 | Masks the invalid flag from `exc_unmasked` |
| mask_den | input | 1 | Masks the denormal flag from `exc_unmasked` |
| out_valid | output | 1 | One-cycle pulse for a new result |
| result | output | 128 | Lane-wise maximum |
| flag_inv | output | 1 | NaN seen in any lane |
| flag_den | output | 1 | Subnormal seen in any lane |
| exc_unmasked | output | 1 | A raised flag whose mask is low |

## Verification
Some wrong results can only be seen in the raw bits. One example is a signalling NaN in the second operand that comes out with its quiet bit set. Another is a +0/-0 pair that returns the first operand's sign. Both produce values that a numeric compare treats as correct.

The stimulus table therefore uses exact bit patterns in both operand orders:
- signalling and quiet NaNs;
- zeros of opposite sign;
- subnormal values next to zero and to infinity.

The table also puts entry i in the low lane and entry 15−i in the high lane. Any leakage between lanes then shows up as a wrong lane value.

// File: rtl/pfmax_pkg.sv
package pfmax_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic is_sub;
    } fp_class_t;

    function automatic logic [MAG_W-1:0] magnitude(input fp_t v);
        return {v.exp, v.frac};
    endfunction

endpackage

// File: rtl/pfmax_classify.sv
module pfmax_classify
    import pfmax_pkg::*;
(
    input  fp_t       val,
    output fp_class_t cls
);
    logic exp_max;
    logic exp_min;
    logic frac_nz;

    always_comb begin
        exp_max     = &val.exp;
        exp_min     = ~|val.exp;
        frac_nz     = |val.frac;
        cls.is_nan  = exp_max && frac_nz;
        cls.is_snan = exp_max && frac_nz && !val.frac[FRAC_W-1];
        cls.is_zero = exp_min && !frac_nz;
        cls.is_sub  = exp_min && frac_nz;
    end
endmodule

// File: rtl/pfmax_order.sv
module pfmax_order
    import pfmax_pkg::*;
(
    input  fp_t  lhs,
    input  fp_t  rhs,
    output logic lhs_gt
);
    logic mag_gt;
    logic mag_lt;

    always_comb begin
        mag_gt = magnitude(lhs) > magnitude(rhs);
        mag_lt = magnitude(lhs) < magnitude(rhs);
        if (lhs.sign != rhs.sign)
            lhs_gt = !lhs.sign;
        else if (!lhs.sign)
            lhs_gt = mag_gt;
        else
            lhs_gt = mag_lt;
    end
endmodule

// File: rtl/pfmax_lane.sv
module pfmax_lane
    import pfmax_pkg::*;
(
    input  fp_t       a,
    input  fp_t       b,
    output fp_t       y,
    output fp_class_t a_cls,
    output fp_class_t b_cls,
    output logic      inv,
    output logic      den
);
    logic a_gt;
    logic take_b;

    pfmax_classify u_cls_a (.val(a), .cls(a_cls));
    pfmax_classify u_cls_b (.val(b), .cls(b_cls));
    pfmax_order    u_ord   (.lhs(a), .rhs(b), .lhs_gt(a_gt));

    always_comb begin
        take_b = a_cls.is_nan || b_cls.is_nan
              || (a_cls.is_zero && b_cls.is_zero)
              || !a_gt;
        y   = take_b ? b : a;
        inv = a_cls.is_nan || b_cls.is_nan;
        den = a_cls.is_sub || b_cls.is_sub;
    end
endmodule

// File: rtl/pfmax_unit.sv
module pfmax_unit
    import pfmax_pkg::*;
#(
    parameter int LANES = 2,
    localparam int DATA_W = LANES * FP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_keep,
    input  logic [DATA_W-1:0] op_alt,
    input  logic              mask_inv,
    input  logic              mask_den,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_inv,
    output logic              flag_den,
    output logic              exc_unmasked
);
    fp_class_t         a_cls [LANES];
    fp_class_t         b_cls [LANES];
    logic [LANES-1:0]  lane_inv;
    logic [LANES-1:0]  lane_den;
    logic [DATA_W-1:0] res_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fp_t y_l;

        pfmax_lane u_lane (
            .a     (fp_t'(op_keep[l*FP_W +: FP_W])),
            .b     (fp_t'(op_alt[l*FP_W +: FP_W])),
            .y     (y_l),
            .a_cls (a_cls[l]),
            .b_cls (b_cls[l]),
            .inv   (lane_inv[l]),
            .den   (lane_den[l])
        );
        assign res_d[l*FP_W +: FP_W] = y_l;

        // R5: a lane with a NaN returns the second operand unchanged.
        p_nan_alt_r5: assert property (@(posedge clk) disable iff (rst)
            in_valid && (a_cls[l].is_nan || b_cls[l].is_nan)
            |=> result[l*FP_W +: FP_W] == $past(op_alt[l*FP_W +: FP_W]));

        // R5: a returned signalling NaN keeps its quiet bit clear.
        p_snan_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            in_valid && b_cls[l].is_snan |=> !result[l*FP_W + FRAC_W - 1]);

        // R4: two zeros return the second operand.
        p_zero_alt_r4: assert property (@(posedge clk) disable iff (rst)
            in_valid && a_cls[l].is_zero && b_cls[l].is_zero
            |=> result[l*FP_W +: FP_W] == $past(op_alt[l*FP_W +: FP_W]));

        // R6: a signalling NaN in either operand raises the invalid flag.
        p_snan_inv_r6: assert property (@(posedge clk) disable iff (rst)
            in_valid && (a_cls[l].is_snan || b_cls[l].is_snan) |=> flag_inv);

        // R7: a subnormal input raises the denormal flag.
        p_sub_den_r7: assert property (@(posedge clk) disable iff (rst)
            in_valid && (a_cls[l].is_sub || b_cls[l].is_sub) |=> flag_den);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_inv     <= 1'b0;
            flag_den     <= 1'b0;
            exc_unmasked <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= res_d;
                flag_inv     <= |lane_inv;
                flag_den     <= |lane_den;
                exc_unmasked <= (|lane_inv && !mask_inv) || (|lane_den && !mask_den);
            end
        end
    end

    // R9: one result pulse per strobe.
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(flag_inv) && $stable(flag_den));

    // R8: an unmasked exception needs a raised flag.
    p_exc_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        exc_unmasked |-> (flag_inv || flag_den));

endmodule

// File: tb/test_pfmax_unit.sv
`timescale 1ns/1ps
module test_pfmax_unit;
    localparam int N = 16;
    // Each entry: keep value, alt value, expected lane result, inv, den.
    localparam logic [193:0] VEC [N] = '{
        {64'h4000000000000000, 64'h3FF0000000000000, 64'h4000000000000000, 1'b0, 1'b0}, // R2 2>1
        {64'h3FF0000000000000, 64'h4000000000000000, 64'h4000000000000000, 1'b0, 1'b0}, // R2
        {64'hBFF0000000000000, 64'hC000000000000000, 64'hBFF0000000000000, 1'b0, 1'b0}, // R2 negatives
        {64'hC000000000000000, 64'hBFF0000000000000, 64'hBFF0000000000000, 1'b0, 1'b0}, // R2
        {64'hBFF0000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b0, 1'b0}, // R2 signs differ
        {64'h3FF0000000000000, 64'hBFF0000000000000, 64'h3FF0000000000000, 1'b0, 1'b0}, // R2
        {64'h0000000000000000, 64'h8000000000000000, 64'h8000000000000000, 1'b0, 1'b0}, // R4 +0,-0
        {64'h8000000000000000, 64'h0000000000000000, 64'h0000000000000000, 1'b0, 1'b0}, // R4 -0,+0
        {64'h4008000000000000, 64'h4008000000000000, 64'h4008000000000000, 1'b0, 1'b0}, // R3 equal
        {64'h7FF8000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b1, 1'b0}, // R5 qnan keep
        {64'h3FF0000000000000, 64'h7FF8000000000000, 64'h7FF8000000000000, 1'b1, 1'b0}, // R5 qnan alt
        {64'h7FF0000000000001, 64'h4000000000000000, 64'h4000000000000000, 1'b1, 1'b0}, // R5 snan keep
        {64'h4000000000000000, 64'h7FF0000000000001, 64'h7FF0000000000001, 1'b1, 1'b0}, // R5 snan alt
        {64'h0000000000000001, 64'h0000000000000000, 64'h0000000000000001, 1'b0, 1'b1}, // R7 sub>0
        {64'hFFF0000000000000, 64'h0000000000000001, 64'h0000000000000001, 1'b0, 1'b1}, // R7 -inf,sub
        {64'h7FF0000000000000, 64'h4008000000000000, 64'h7FF0000000000000, 1'b0, 1'b0}  // R2 +inf
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] op_keep = '0;
    logic [127:0] op_alt = '0;
    logic         mask_inv = 1'b0;
    logic         mask_den = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         flag_inv;
    logic         flag_den;
    logic         exc_unmasked;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pfmax_unit i_pfmax_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_keep(op_keep), .op_alt(op_alt),
        .mask_inv(mask_inv), .mask_den(mask_den),
        .out_valid(out_valid), .result(result),
        .flag_inv(flag_inv), .flag_den(flag_den),
        .exc_unmasked(exc_unmasked)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] a, input logic [127:0] b,
                         input logic mi, input logic md);
        @(negedge clk);
        op_keep = a; op_alt = b; mask_inv = mi; mask_den = md; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", {127'd0, out_valid}, 128'd0);
        check("R10 result", result, 128'd0);
        check("R10 flags", {125'd0, flag_inv, flag_den, exc_unmasked}, 128'd0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7 R8: table walk, entry i low lane, entry N-1-i high lane
        for (int i = 0; i < N; i++) begin
            logic [193:0] lo;
            logic [193:0] hi;
            logic ei, ed, mi, md;
            lo = VEC[i];
            hi = VEC[N-1-i];
            mi = i[0];
            md = i[1];
            ei = lo[1] | hi[1];
            ed = lo[0] | hi[0];
            apply({hi[193:130], lo[193:130]}, {hi[129:66], lo[129:66]}, mi, md);
            check("R9 out_valid", {127'd0, out_valid}, 128'd1);
            check("R1 R2 R3 R4 R5 result", result, {hi[65:2], lo[65:2]});
            check("R6 flag_inv", {127'd0, flag_inv}, {127'd0, ei});
            check("R7 flag_den", {127'd0, flag_den}, {127'd0, ed});
            check("R8 exc_unmasked", {127'd0, exc_unmasked},
                  {127'd0, (ei & ~mi) | (ed & ~md)});
        end

        // R9: hold when no strobe, operands changing
        apply({64'h7FF0000000000001, 64'h4000000000000000},
              {64'h3FF0000000000000, 64'h0000000000000001}, 1'b0, 1'b0);
        op_keep = '0; op_alt = {2{64'hC000000000000000}};
        @(negedge clk);
        check("R9 no pulse", {127'd0, out_valid}, 128'd0);
        check("R9 hold result", result, {64'h3FF0000000000000, 64'h4000000000000000});
        check("R9 hold flags", {125'd0, flag_inv, flag_den, exc_unmasked}, 128'd7);

        // R9: back-to-back strobes
        @(negedge clk);
        op_keep = {64'h3FF0000000000000, 64'h4000000000000000};
        op_alt  = {64'h4000000000000000, 64'h3FF0000000000000};
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 b2b first valid", {127'd0, out_valid}, 128'd1);
        check("R9 b2b first", result, {64'h4000000000000000, 64'h4000000000000000});
        op_keep = {64'h8000000000000000, 64'hBFF0000000000000};
        op_alt  = {64'h0000000000000000, 64'hC000000000000000};
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 b2b second valid", {127'd0, out_valid}, 128'd1);
        check("R4 R2 b2b second", result, {64'h0000000000000000, 64'hBFF0000000000000});
        @(negedge clk);
        check("R9 pulse ends", {127'd0, out_valid}, 128'd0);

        // R10: reset mid-run clears captured state
        apply({2{64'h7FF8000000000000}}, {2{64'h3FF0000000000000}}, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check("R10 result after reset", result, 128'd0);
        check("R10 flags after reset", {125'd0, flag_inv, flag_den, exc_unmasked}, 128'd0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule